// File: doc/BRIEF.md
# Pulse Zero-Crossing Timestamp Detector

This block watches a stream of signed converter samples that carry a pulsed 100 kHz carrier. At a 1 MHz sample rate, one carrier cycle spans about ten samples. Each sample is marked by a one-cycle sample enable. A small state machine waits for a sample whose magnitude is above a programmable threshold, which marks the onset of a pulse. It then counts carrier sign changes. A hysteresis band stops noise close to zero from being counted as a crossing. The third crossing after onset is the timing point of the pulse.

A free-running sample counter gives each timing point its timestamp. The block copies that value into a holding register, sets an interrupt-pending bit and ignores the input for a programmable lockout window before it arms again. If a second timing point arrives before software has serviced the first, the first timestamp is kept and an overflow bit is set. A processor reads the status, the timestamp and an enable over a small register bus. Reading the status clears the pending and overflow bits. The delay between two pulses is the difference between their timestamps.

Top module: `zc_stamp_top`

## Requirements
- R1: After reset, `irq` is low, and the status (address 0), timestamp (address 1) and control (address 2) registers all read as zero.
- R2: The timestamp counter is 32 bits wide. It advances by one on each cycle with `smp_en` high, holds on all other cycles and wraps silently. A captured timestamp equals the number of enabled samples accepted since reset, not counting the sample that completed the third crossing.
- R3: While the detector is idle, a sample starts a pulse only if its magnitude is strictly greater than `cfg_thresh`. Samples whose magnitude is equal to or below the threshold leave the detector idle.
- R4: A sample is positive if it is greater than `cfg_hyst`, negative if it is less than minus `cfg_hyst`, and otherwise inside the band. The onset sample sets the reference sign. A crossing is counted when a positive or negative sample has the sign opposite to the reference, and that sample becomes the new reference. Samples inside the band change nothing.
- R5: The third crossing after onset is the timing point. Its timestamp is captured.
- R6: After a timing point, the next `cfg_lockout` enabled samples are ignored. Detection then returns to idle. A lockout of zero re-arms at the very next sample.
- R7: A timing point with no interrupt pending loads the timestamp register and sets status bit 0 (pending). A timing point that arrives while pending is set sets status bit 1 (overflow) and leaves the stored timestamp unchanged.
- R8: A read of address 0 returns the status and clears both the pending and overflow bits. If a timing point arrives in the same cycle, it counts as arriving after the clear.
- R9: `irq` equals status bit 0 ANDed with control bit 0 (interrupt enable, at address 2, which can be read and written).
- R10: Reads of unmapped addresses return zero. Writes to any address other than 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_en | input | 1 | Marks a valid sample for one cycle |
| smp_data | input | SAMPLE_W | Two's complement sample |
| cfg_thresh | input | SAMPLE_W-1 | Onset magnitude threshold |
| cfg_hyst | input | SAMPLE_W-1 | Half-width of the zero band |
| cfg_lockout | input | LOCK_W | Samples ignored after a timing point |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check the following:
- the counter steps only on enabled samples;
- the held timestamp stays stable while an interrupt is pending;
- overflow only ever appears on top of a pending bit;
- a status read clears both flags;
- the interrupt is never raised without both pending and enable;
- timing points never occur back to back.

Only the bench scenarios can show where the timing point lands in the stream. These scenarios cover onset right at the threshold, band noise with and without hysteresis, several carrier half-periods, and the exact length of the lockout window. The bench computes the expected sample index for each of them arithmetically.

// File: rtl/zc_stamp_pkg.sv
package zc_stamp_pkg;

   typedef enum logic [1:0] {
      ZC_IDLE  = 2'd0,
      ZC_COUNT = 2'd1,
      ZC_LOCK  = 2'd2
   } zc_state_e;

   typedef enum logic [1:0] {
      RG_BAND = 2'd0,
      RG_POS  = 2'd1,
      RG_NEG  = 2'd2
   } zc_region_e;

   localparam int unsigned ADR_STATUS  = 0;
   localparam int unsigned ADR_STAMP   = 1;
   localparam int unsigned ADR_CTRL    = 2;
   localparam int unsigned ST_PEND_BIT = 0;
   localparam int unsigned ST_OVF_BIT  = 1;
   localparam int unsigned CT_EN_BIT   = 0;

endpackage

// File: rtl/zc_time_base.sv
module zc_time_base #(
   parameter int unsigned STAMP_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   output logic [STAMP_W-1:0] now_o
);

   // free-running sample counter, wraps silently
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      now_o <= '0;
      else if (tick_i) now_o <= now_o + 1'b1;
   end

endmodule

// File: rtl/zc_edge_fsm.sv
module zc_edge_fsm
   import zc_stamp_pkg::*;
#(
   parameter int unsigned SAMPLE_W     = 12,
   parameter int unsigned STAMP_W      = 32,
   parameter int unsigned LOCK_W       = 16,
   parameter int unsigned CROSS_TARGET = 3,
   parameter bit          HYST_EN      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_en_i,
   input  logic [SAMPLE_W-1:0] smp_i,
   input  logic [SAMPLE_W-2:0] thr_i,
   input  logic [SAMPLE_W-2:0] hyst_i,
   input  logic [LOCK_W-1:0]   lock_i,
   input  logic [STAMP_W-1:0]  now_i,
   output logic                evt_o,
   output logic [STAMP_W-1:0]  evt_stamp_o,
   output zc_state_e           state_o
);

   localparam int unsigned EW = SAMPLE_W + 1;
   localparam int unsigned CW = $clog2(CROSS_TARGET + 1);
   localparam logic [CW-1:0] LAST_XING = CW'(CROSS_TARGET - 1);

   logic signed [EW-1:0] sx, tx, hx;
   logic                 onset;
   zc_region_e           region;
   zc_state_e            state_q;
   logic                 ref_neg_q;
   logic [CW-1:0]        xcnt_q;
   logic [LOCK_W-1:0]    remain_q;
   logic                 flip;

   assign sx = $signed({smp_i[SAMPLE_W-1], smp_i});
   assign tx = $signed({2'b00, thr_i});

   // variant: programmable band or pure sign detection
   generate
      if (HYST_EN) begin : g_band
         assign hx = $signed({2'b00, hyst_i});
      end else begin : g_sign
         logic [SAMPLE_W-2:0] unused_hyst;
         assign unused_hyst = hyst_i;
         assign hx = '0;
      end
   endgenerate

   assign onset = (sx > tx) || (sx < -tx);

   always_comb begin
      if (sx > hx)       region = RG_POS;
      else if (sx < -hx) region = RG_NEG;
      else               region = RG_BAND;
   end

   assign flip = (region != RG_BAND) && ((region == RG_NEG) != ref_neg_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ZC_IDLE;
         ref_neg_q   <= 1'b0;
         xcnt_q      <= '0;
         remain_q    <= '0;
         evt_o       <= 1'b0;
         evt_stamp_o <= '0;
      end else begin
         evt_o <= 1'b0;
         if (smp_en_i) begin
            unique case (state_q)
               ZC_IDLE: begin
                  if (onset) begin
                     state_q   <= ZC_COUNT;
                     ref_neg_q <= sx[EW-1];
                     xcnt_q    <= '0;
                  end
               end
               ZC_COUNT: begin
                  if (flip) begin
                     ref_neg_q <= (region == RG_NEG);
                     if (xcnt_q == LAST_XING) begin
                        evt_o       <= 1'b1;
                        evt_stamp_o <= now_i;
                        remain_q    <= lock_i;
                        state_q     <= (lock_i == '0) ? ZC_IDLE : ZC_LOCK;
                     end else begin
                        xcnt_q <= xcnt_q + 1'b1;
                     end
                  end
               end
               ZC_LOCK: begin
                  remain_q <= remain_q - 1'b1;
                  if (remain_q <= LOCK_W'(1)) state_q <= ZC_IDLE;
               end
               default: state_q <= ZC_IDLE;
            endcase
         end
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/zc_irq_regs.sv
module zc_irq_regs
   import zc_stamp_pkg::*;
#(
   parameter int unsigned STAMP_W = 32,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               evt_i,
   input  logic [STAMP_W-1:0] evt_stamp_i,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq,
   output logic               pend_o,
   output logic               ovf_o,
   output logic               en_o,
   output logic [STAMP_W-1:0] stamp_o,
   output logic               rd_status_o
);

   logic hit_status, hit_stamp, hit_ctrl;
   logic [DATA_W-1:0] unused_wdata;

   assign unused_wdata = bus_wdata;
   assign hit_status   = (bus_addr == ADDR_W'(ADR_STATUS));
   assign hit_stamp    = (bus_addr == ADDR_W'(ADR_STAMP));
   assign hit_ctrl     = (bus_addr == ADDR_W'(ADR_CTRL));
   assign rd_status_o  = bus_sel && !bus_we && hit_status;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_o  <= 1'b0;
         ovf_o   <= 1'b0;
         en_o    <= 1'b0;
         stamp_o <= '0;
      end else begin
         if (rd_status_o) begin
            pend_o <= 1'b0;
            ovf_o  <= 1'b0;
         end
         if (evt_i) begin
            if (pend_o && !rd_status_o) begin
               ovf_o <= 1'b1;
            end else begin
               pend_o  <= 1'b1;
               stamp_o <= evt_stamp_i;
            end
         end
         if (bus_sel && bus_we && hit_ctrl) en_o <= bus_wdata[CT_EN_BIT];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_status) begin
         bus_rdata[ST_PEND_BIT] = pend_o;
         bus_rdata[ST_OVF_BIT]  = ovf_o;
      end else if (hit_stamp) begin
         bus_rdata = DATA_W'(stamp_o);
      end else if (hit_ctrl) begin
         bus_rdata[CT_EN_BIT] = en_o;
      end
   end

   assign irq = pend_o & en_o;

endmodule

// File: rtl/zc_stamp_top.sv
module zc_stamp_top
   import zc_stamp_pkg::*;
#(
   parameter int unsigned SAMPLE_W     = 12,
   parameter int unsigned STAMP_W      = 32,
   parameter int unsigned LOCK_W       = 16,
   parameter int unsigned ADDR_W       = 2,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned CROSS_TARGET = 3,
   parameter bit          HYST_EN      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_en,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [SAMPLE_W-2:0] cfg_thresh,
   input  logic [SAMPLE_W-2:0] cfg_hyst,
   input  logic [LOCK_W-1:0]   cfg_lockout,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                irq
);

   generate
      if (SAMPLE_W < 4)        begin : g_bad_sw   $fatal(1, "SAMPLE_W must be at least 4"); end
      if (DATA_W < STAMP_W)    begin : g_bad_dw   $fatal(1, "DATA_W must hold a timestamp"); end
      if (ADDR_W < 2)          begin : g_bad_aw   $fatal(1, "ADDR_W must reach three registers"); end
      if (CROSS_TARGET < 1)    begin : g_bad_ct   $fatal(1, "CROSS_TARGET must be positive"); end
      if (LOCK_W < 1)          begin : g_bad_lw   $fatal(1, "LOCK_W must be positive"); end
   endgenerate

   logic [STAMP_W-1:0] now;
   logic               evt;
   logic [STAMP_W-1:0] evt_stamp;
   zc_state_e          state;
   logic               pend, ovf, en, rd_status;
   logic [STAMP_W-1:0] stamp;

   zc_time_base #(.STAMP_W(STAMP_W)) u_time (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (smp_en),
      .now_o  (now)
   );

   zc_edge_fsm #(
      .SAMPLE_W     (SAMPLE_W),
      .STAMP_W      (STAMP_W),
      .LOCK_W       (LOCK_W),
      .CROSS_TARGET (CROSS_TARGET),
      .HYST_EN      (HYST_EN)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_en_i    (smp_en),
      .smp_i       (smp_data),
      .thr_i       (cfg_thresh),
      .hyst_i      (cfg_hyst),
      .lock_i      (cfg_lockout),
      .now_i       (now),
      .evt_o       (evt),
      .evt_stamp_o (evt_stamp),
      .state_o     (state)
   );

   zc_irq_regs #(
      .STAMP_W (STAMP_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_i       (evt),
      .evt_stamp_i (evt_stamp),
      .bus_sel     (bus_sel),
      .bus_we      (bus_we),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .irq         (irq),
      .pend_o      (pend),
      .ovf_o       (ovf),
      .en_o        (en),
      .stamp_o     (stamp),
      .rd_status_o (rd_status)
   );

endmodule

// File: rtl/zc_stamp_chk.sv
module zc_stamp_chk
   import zc_stamp_pkg::*;
#(
   parameter int unsigned STAMP_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               smp_en,
   input logic [STAMP_W-1:0] now,
   input logic               evt,
   input zc_state_e          state,
   input logic               pend,
   input logic               ovf,
   input logic               en,
   input logic [STAMP_W-1:0] stamp,
   input logic               rd_status,
   input logic               irq
);

   AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      smp_en |=> now == STAMP_W'($past(now) + 1'b1));                        // R2
   AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en |=> $stable(now));                                            // R2
   AST_EVT_FROM_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(evt) |-> $past(state) == ZC_COUNT && $past(smp_en));            // R5
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt);                                                        // R6
   AST_STAMP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !rd_status |=> $stable(stamp));                               // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(pend));                                          // R7
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_status && !evt |=> !pend && !ovf);                                 // R8
   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !irq);                                                        // R9
   AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pend);                                                        // R9

endmodule

bind zc_stamp_top zc_stamp_chk #(.STAMP_W(STAMP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_en    (smp_en),
   .now       (now),
   .evt       (evt),
   .state     (state),
   .pend      (pend),
   .ovf       (ovf),
   .en        (en),
   .stamp     (stamp),
   .rd_status (rd_status),
   .irq       (irq)
);

// File: tb/tb_zc_stamp_top.sv
module tb_zc_stamp_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_en = 1'b0;
   logic [11:0] smp_data = '0;
   logic [10:0] cfg_thresh = 11'd200;
   logic [10:0] cfg_hyst = 11'd50;
   logic [15:0] cfg_lockout = 16'd4;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int   n_chk = 0;
   int   n_fail = 0;
   int   sidx = 0;
   bit   done = 1'b0;

   always #5 clk = ~clk;

   zc_stamp_top dut (
      .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .smp_data(smp_data),
      .cfg_thresh(cfg_thresh), .cfg_hyst(cfg_hyst), .cfg_lockout(cfg_lockout),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   // one enabled sample every four clocks
   task automatic feed(input int v);
      @(negedge clk);
      smp_en = 1'b1; smp_data = v[11:0];
      @(negedge clk);
      smp_en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      sidx++;
   endtask

   task automatic sq(input int half, input int n, input int amp);
      for (int k = 0; k < n; k++) feed(((k / half) % 2 == 0) ? amp : -amp);
   endtask

   task automatic quiet(input int n);
      for (int k = 0; k < n; k++) feed(0);
   endtask

   // check irq, stamp, status, then that the status read cleared it
   task automatic expect_evt(input string req, input int stamp_exp, input int st_exp);
      logic [31:0] d;
      chk({req, " irq"}, {31'd0, irq}, 32'd1);
      bus_rd(2'd1, d);
      chk({req, " stamp"}, d, stamp_exp);
      bus_rd(2'd0, d);
      chk({req, " status"}, d, st_exp);
      bus_rd(2'd0, d);
      chk("R8 status after read", d, 32'd0);
      chk("R9 irq after read", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      logic [31:0] d;
      int s0;
      int halves[4] = '{2, 3, 5, 8};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {31'd0, irq}, 32'd0);
      bus_rd(2'd0, d); chk("R1 status", d, 32'd0);
      bus_rd(2'd1, d); chk("R1 stamp", d, 32'd0);
      bus_rd(2'd2, d); chk("R1 ctrl", d, 32'd0);

      // R10 map: unmapped read, writes outside control ignored
      bus_rd(2'd3, d); chk("R10 unmapped", d, 32'd0);
      bus_wr(2'd0, 32'hFFFF_FFFF);
      bus_wr(2'd1, 32'h1234_5678);
      bus_rd(2'd1, d); chk("R10 stamp unwritable", d, 32'd0);
      bus_rd(2'd0, d); chk("R10 status unwritable", d, 32'd0);
      bus_wr(2'd2, 32'd1);
      bus_rd(2'd2, d); chk("R9 ctrl enable", d, 32'd1);

      // R5 R2 third crossing over several half-periods
      foreach (halves[i]) begin
         s0 = sidx;
         sq(halves[i], 3 * halves[i] + 1, 1000);
         quiet(10);
         expect_evt("R5 R2 period sweep", s0 + 3 * halves[i], 32'd1);
      end

      // R3 onset must be strictly above threshold
      sq(3, 20, 150);
      sq(3, 20, 200);
      quiet(2);
      chk("R3 no onset irq", {31'd0, irq}, 32'd0);
      bus_rd(2'd0, d); chk("R3 no onset status", d, 32'd0);
      s0 = sidx;
      sq(2, 7, 201);
      quiet(10);
      expect_evt("R3 onset just above", s0 + 6, 32'd1);

      // R4 band noise with hysteresis, then without
      cfg_lockout = 16'd8;
      for (int h = 0; h < 2; h++) begin
         cfg_hyst = (h == 0) ? 11'd50 : 11'd0;
         s0 = sidx;
         feed(1000); feed(1000); feed(1000);
         feed(30); feed(-30); feed(30); feed(-30);
         feed(-1000); feed(-1000); feed(-1000);
         feed(1000); feed(1000); feed(1000);
         feed(-1000);
         quiet(10);
         if (h == 0) expect_evt("R4 band ignored", s0 + 13, 32'd1);
         else        expect_evt("R4 no band", s0 + 6, 32'd1);
      end
      cfg_hyst = 11'd50;

      // R6 R7 lockout 8 without service: overflow keeps first stamp
      s0 = sidx;
      sq(3, 30, 1000);
      quiet(12);
      expect_evt("R7 overflow keeps old", s0 + 9, 32'd3);

      // R6 lockout 8, service after first: re-arm lands at +27
      s0 = sidx;
      for (int k = 0; k < 30; k++) begin
         feed(((k / 3) % 2 == 0) ? 1000 : -1000);
         if (k == 9) begin
            bus_rd(2'd1, d); chk("R6 first stamp", d, s0 + 9);
            bus_rd(2'd0, d); chk("R8 first status", d, 32'd1);
         end
      end
      quiet(12);
      expect_evt("R6 lockout 8 rearm", s0 + 27, 32'd1);

      // R6 lockout zero re-arms at next sample
      cfg_lockout = 16'd0;
      s0 = sidx;
      for (int k = 0; k < 28; k++) begin
         feed(((k / 3) % 2 == 0) ? 1000 : -1000);
         if (k == 9) bus_rd(2'd0, d);
      end
      quiet(4);
      expect_evt("R6 lockout 0 rearm", s0 + 18, 32'd3);
      cfg_lockout = 16'd4;

      // R9 disabled interrupt stays low while pending
      bus_wr(2'd2, 32'd0);
      s0 = sidx;
      sq(4, 13, 1000);
      quiet(10);
      chk("R9 irq masked", {31'd0, irq}, 32'd0);
      bus_rd(2'd2, d); chk("R9 ctrl cleared", d, 32'd0);
      bus_wr(2'd2, 32'd1);
      expect_evt("R9 unmask", s0 + 12, 32'd1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule